// File: doc/BRIEF.md
# Burst Frame Buffer with Multi-Link Serial Drain

The block sits behind a pixel digitizer and stores one burst of frames at full acquisition speed. Nothing is sent out while the burst is being captured. A trigger, accepted only while the buffer is empty, opens a burst. The block then stores a fixed number of frames of 8-bit samples. Each frame is delimited by a start marker on its first sample and an end marker on its last sample.

Once the last frame of the burst has been stored, the block plays the burst back. It forms one byte stream in which every frame is wrapped in overhead: a sync byte and a 16-bit frame number go in front of the payload, and a 16-bit checksum follows it. That stream is dealt across a configurable number of parallel serial links, and each link shifts its bytes out most significant bit first. The links run either at the full clock rate or at half of it. While no burst is waiting, the active links carry an idle byte.

The burst length is a parameter. The full-size application uses 100 frames per burst; the default here is a small model of the storage.

Top module: `burst_frame_buffer`

## Requirements
- R1: While reset is asserted, `busy_o` and `overflow_o` are 0 and every bit of `link_o` is 0.
- R2: When `burst_trig_i` is high while `busy_o` is 0, `busy_o` is 1 on the next cycle and capture starts. The block then stores BURST_FRAMES frames of FRAME_BYTES samples each. A frame starts on a valid sample with `pix_sof_i` and ends on a valid sample with `pix_eof_i`. Samples presented while the block is not busy are not stored.
- R3: After the last frame is stored, the burst stream is sent frame by frame. Each frame is the byte 0xA5, then the frame number (high byte, then low byte), then the payload in arrival order, then the 16-bit modulo sum of the payload bytes (high byte, then low byte).
- R4: Let L be the number of active links. Byte k of the burst stream goes to link k mod L. All links start each byte on the same bit time, and each byte is sent most significant bit first. In the last group, any link that has no stream byte left sends 0x3C.
- R5: `cfg_links_i` sets L. A value of 0 means one link, and a value above NUM_LINKS means NUM_LINKS. Links L and above hold 0. The setting, and the rate select, are taken only while the block is idle.
- R6: With `cfg_half_rate_i` at 0, each bit lasts one clock cycle. With it at 1, each bit lasts two clock cycles.
- R7: Frame numbers are 16 bits wide and start at 0 after reset. They increase by one for every stored frame and carry on across bursts.
- R8: A trigger that arrives while `busy_o` is 1 has no effect.
- R9: A frame start that arrives while the buffer holds a complete burst sets `overflow_o`. The flag stays set until reset. The data of that frame is dropped and does not advance the frame number.
- R10: While no burst is waiting to be sent, every active link sends the byte 0x3C repeatedly.
- R11: `busy_o` falls once the last group of bytes has been handed to the links. After that, a new trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_trig_i | input | 1 | Starts a burst capture when the block is idle |
| pix_valid_i | input | 1 | Pixel sample valid |
| pix_sof_i | input | 1 | First sample of a frame |
| pix_eof_i | input | 1 | Last sample of a frame |
| pix_data_i | input | 8 | Pixel sample |
| cfg_links_i | input | $clog2(NUM_LINKS+1) | Requested number of active links |
| cfg_half_rate_i | input | 1 | 1 selects one bit every two clock cycles |
| link_o | output | NUM_LINKS | Serial bit of each link |
| busy_o | output | 1 | Burst capture or drain in progress |
| overflow_o | output | 1 | Sticky flag for a frame refused while the buffer was full |

## Verification
The hardest situation to bring about is a frame start that arrives while a complete burst still sits in memory. The buffer is full only between the last end marker of a burst and the handover of the last byte group. The bench reaches that window by sending one more frame, together with a second trigger, right after the final frame of a burst. It uses five links, so the drain lasts longer than the extra frame. It then checks three things: the drained stream is unchanged, the next burst's frame numbers did not advance, and the flag is still set one burst later. Stream alignment across links is recovered from the sync byte on link 0. The bench deliberately sets up a partial final group so that it can check the padding on the unused lanes.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;
    localparam logic [7:0] IDLE_BYTE = 8'h3C;
    localparam int OVH_HEAD = 3;
    localparam int OVH_TAIL = 2;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_FILL = 2'd1,
        CAP_FULL = 2'd2
    } cap_st_e;
endpackage

// File: rtl/bfb_capture.sv
module bfb_capture
    import bfb_pkg::*;
#(
    parameter int BURST_FRAMES = 4,
    parameter int FRAME_BYTES  = 8,
    localparam int MEM_BYTES   = BURST_FRAMES * FRAME_BYTES,
    localparam int AW          = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
    localparam int FW          = (BURST_FRAMES > 1) ? $clog2(BURST_FRAMES) : 1,
    localparam int IW          = $clog2(FRAME_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic        pix_valid_i,
    input  logic        pix_sof_i,
    input  logic        pix_eof_i,
    input  logic [7:0]  pix_data_i,
    input  logic        drain_done_i,
    output logic [7:0]  mem_o [MEM_BYTES],
    output logic [15:0] csum_o [BURST_FRAMES],
    output logic [15:0] base_fn_o,
    output logic        full_o,
    output logic        busy_o,
    output logic        overflow_o
);
    typedef struct packed {
        cap_st_e        st;
        logic [FW-1:0]  slot;
        logic [IW-1:0]  idx;
        logic           in_frm;
        logic [15:0]    sum;
        logic [15:0]    fn;
        logic [15:0]    base;
        logic           ovf;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [7:0]    mem_q  [MEM_BYTES];
    logic [15:0]   csum_q [BURST_FRAMES];
    logic          wr_en, cs_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   cs_val;
    logic [IW-1:0] cur_idx;
    logic [15:0]   cur_sum;

    always_comb begin
        cap_d   = cap_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        cs_en   = 1'b0;
        cs_val  = cap_q.sum;
        cur_idx = '0;
        cur_sum = '0;
        case (cap_q.st)
            CAP_IDLE: begin
                if (trig_i) begin
                    cap_d.st     = CAP_FILL;
                    cap_d.slot   = '0;
                    cap_d.in_frm = 1'b0;
                    cap_d.base   = cap_q.fn;
                end
            end
            CAP_FILL: begin
                if (pix_valid_i && (pix_sof_i || cap_q.in_frm)) begin
                    cur_idx      = pix_sof_i ? '0 : cap_q.idx;
                    cur_sum      = pix_sof_i ? '0 : cap_q.sum;
                    cap_d.in_frm = 1'b1;
                    cap_d.idx    = cur_idx;
                    cap_d.sum    = cur_sum;
                    if (int'(cur_idx) < FRAME_BYTES) begin
                        wr_en     = 1'b1;
                        wr_addr   = AW'(int'(cap_q.slot) * FRAME_BYTES + int'(cur_idx));
                        cap_d.sum = cur_sum + 16'(pix_data_i);
                        cap_d.idx = cur_idx + 1'b1;
                    end
                    if (pix_eof_i) begin
                        cs_en        = 1'b1;
                        cs_val       = cap_d.sum;
                        cap_d.in_frm = 1'b0;
                        cap_d.fn     = cap_q.fn + 16'd1;
                        if (int'(cap_q.slot) == BURST_FRAMES - 1) begin
                            cap_d.st = CAP_FULL;
                        end else begin
                            cap_d.slot = cap_q.slot + 1'b1;
                        end
                    end
                end
            end
            CAP_FULL: begin
                if (pix_valid_i && pix_sof_i) begin
                    cap_d.ovf = 1'b1;
                end
                if (drain_done_i) begin
                    cap_d.st = CAP_IDLE;
                end
            end
            default: cap_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= pix_data_i;
        end
        if (cs_en) begin
            csum_q[cap_q.slot] <= cs_val;
        end
    end

    assign mem_o      = mem_q;
    assign csum_o     = csum_q;
    assign base_fn_o  = cap_q.base;
    assign full_o     = (cap_q.st == CAP_FULL);
    assign busy_o     = (cap_q.st != CAP_IDLE);
    assign overflow_o = cap_q.ovf;

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !drain_done_i) |=> busy_o);
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $past(full_o && pix_valid_i && pix_sof_i));
endmodule

// File: rtl/bfb_drain.sv
module bfb_drain
    import bfb_pkg::*;
#(
    parameter int NUM_LINKS    = 8,
    parameter int BURST_FRAMES = 4,
    parameter int FRAME_BYTES  = 8,
    localparam int MEM_BYTES   = BURST_FRAMES * FRAME_BYTES,
    localparam int AW          = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
    localparam int FW          = (BURST_FRAMES > 1) ? $clog2(BURST_FRAMES) : 1,
    localparam int LW          = $clog2(NUM_LINKS + 1),
    localparam int PER         = FRAME_BYTES + OVH_HEAD + OVH_TAIL,
    localparam int TOTAL       = BURST_FRAMES * PER,
    localparam int GW          = $clog2(TOTAL + NUM_LINKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           mem_i [MEM_BYTES],
    input  logic [15:0]          csum_i [BURST_FRAMES],
    input  logic [15:0]          base_fn_i,
    input  logic                 full_i,
    input  logic                 busy_i,
    input  logic [LW-1:0]        cfg_links_i,
    input  logic                 cfg_half_i,
    output logic                 done_o,
    output logic [NUM_LINKS-1:0] link_o
);
    typedef struct packed {
        logic                      active;
        logic [GW-1:0]             gidx;
        logic [2:0]                bitcnt;
        logic                      phase;
        logic                      half;
        logic [LW-1:0]             links;
        logic [NUM_LINKS-1:0][7:0] sh;
    } drn_t;

    drn_t drn_d, drn_q;
    logic          tick, src, latch;
    logic [LW-1:0] eff_links, use_links;
    int            base, nb;

    function automatic logic [7:0] byte_at(input int g);
        int          f, p;
        logic [15:0] fnum;
        f    = g / PER;
        p    = g % PER;
        fnum = base_fn_i + 16'(f);
        if (p == 0)            return SYNC_BYTE;
        else if (p == 1)       return fnum[15:8];
        else if (p == 2)       return fnum[7:0];
        else if (p == PER - 2) return csum_i[FW'(f)][15:8];
        else if (p == PER - 1) return csum_i[FW'(f)][7:0];
        else                   return mem_i[AW'(f * FRAME_BYTES + p - OVH_HEAD)];
    endfunction

    always_comb begin
        if (cfg_links_i == '0)                 eff_links = LW'(1);
        else if (int'(cfg_links_i) > NUM_LINKS) eff_links = LW'(NUM_LINKS);
        else                                    eff_links = cfg_links_i;
    end

    always_comb begin
        drn_d       = drn_q;
        done_o      = 1'b0;
        drn_d.phase = ~drn_q.phase;
        tick        = !drn_q.half || drn_q.phase;
        src         = drn_q.active || full_i;
        latch       = !drn_q.active && !busy_i;
        use_links   = latch ? eff_links : drn_q.links;
        base        = drn_q.active ? int'(drn_q.gidx) : 0;
        nb          = base + int'(use_links);
        if (tick) begin
            if (drn_q.bitcnt == 3'd7) begin
                drn_d.bitcnt = 3'd0;
                if (latch) begin
                    drn_d.links = eff_links;
                    drn_d.half  = cfg_half_i;
                end
                for (int l = 0; l < NUM_LINKS; l++) begin
                    if (l >= int'(use_links))          drn_d.sh[l] = 8'h00;
                    else if (src && base + l < TOTAL)  drn_d.sh[l] = byte_at(base + l);
                    else                               drn_d.sh[l] = IDLE_BYTE;
                end
                if (src) begin
                    if (nb >= TOTAL) begin
                        drn_d.active = 1'b0;
                        drn_d.gidx   = '0;
                        done_o       = 1'b1;
                    end else begin
                        drn_d.active = 1'b1;
                        drn_d.gidx   = GW'(nb);
                    end
                end
            end else begin
                drn_d.bitcnt = drn_q.bitcnt + 3'd1;
                for (int l = 0; l < NUM_LINKS; l++) begin
                    drn_d.sh[l] = {drn_q.sh[l][6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drn_q        <= '0;
            drn_q.bitcnt <= 3'd7;
        end else begin
            drn_q <= drn_d;
        end
    end

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lane
        assign link_o[l] = drn_q.sh[l][7];
        always @(posedge clk) begin
            if (rst_n && (l >= int'(drn_q.links))) begin
                assert_unused_lane_low_R5: assert (link_o[l] == 1'b0);
            end
        end
    end

    assert_done_needs_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> full_i);
    assert_half_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_q.half && !drn_q.phase) |=> $stable(link_o));
endmodule

// File: rtl/burst_frame_buffer.sv
module burst_frame_buffer #(
    parameter int NUM_LINKS    = 8,
    parameter int BURST_FRAMES = 4,
    parameter int FRAME_BYTES  = 8,
    localparam int LW          = $clog2(NUM_LINKS + 1),
    localparam int MEM_BYTES   = BURST_FRAMES * FRAME_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burst_trig_i,
    input  logic                 pix_valid_i,
    input  logic                 pix_sof_i,
    input  logic                 pix_eof_i,
    input  logic [7:0]           pix_data_i,
    input  logic [LW-1:0]        cfg_links_i,
    input  logic                 cfg_half_rate_i,
    output logic [NUM_LINKS-1:0] link_o,
    output logic                 busy_o,
    output logic                 overflow_o
);
    logic [7:0]  mem_w  [MEM_BYTES];
    logic [15:0] csum_w [BURST_FRAMES];
    logic [15:0] base_fn_w;
    logic        full_w, done_w;

    bfb_capture #(
        .BURST_FRAMES(BURST_FRAMES),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (burst_trig_i),
        .pix_valid_i (pix_valid_i),
        .pix_sof_i   (pix_sof_i),
        .pix_eof_i   (pix_eof_i),
        .pix_data_i  (pix_data_i),
        .drain_done_i(done_w),
        .mem_o       (mem_w),
        .csum_o      (csum_w),
        .base_fn_o   (base_fn_w),
        .full_o      (full_w),
        .busy_o      (busy_o),
        .overflow_o  (overflow_o)
    );

    bfb_drain #(
        .NUM_LINKS   (NUM_LINKS),
        .BURST_FRAMES(BURST_FRAMES),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_i      (mem_w),
        .csum_i     (csum_w),
        .base_fn_i  (base_fn_w),
        .full_i     (full_w),
        .busy_i     (busy_o),
        .cfg_links_i(cfg_links_i),
        .cfg_half_i (cfg_half_rate_i),
        .done_o     (done_w),
        .link_o     (link_o)
    );
endmodule

// File: tb/burst_frame_buffer_bench.sv
module burst_frame_buffer_bench;
    localparam int NL    = 8;
    localparam int FR    = 4;
    localparam int FB    = 8;
    localparam int LW    = $clog2(NL + 1);
    localparam int PER   = FB + 5;
    localparam int TOTAL = FR * PER;
    localparam int RXMAX = TOTAL + NL + 8;

    typedef struct packed {
        logic [3:0] links;
        logic       half;
        logic [7:0] seed;
        logic       gap;
        logic [3:0] exp_l;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{4'd1,  1'b0, 8'h10, 1'b0, 4'd1},
        '{4'd3,  1'b1, 8'h42, 1'b1, 4'd3},
        '{4'd8,  1'b0, 8'h9C, 1'b0, 4'd8},
        '{4'd0,  1'b0, 8'hE7, 1'b1, 4'd1},
        '{4'd12, 1'b1, 8'h01, 1'b0, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0, pv = 1'b0, psof = 1'b0, peof = 1'b0;
    logic [7:0]    pdata = 8'h00;
    logic [LW-1:0] cfg_links = LW'(1);
    logic          cfg_half = 1'b0;
    logic [NL-1:0] link;
    logic          busy, ovf;

    int n_chk = 0, n_fail = 0;
    int fn_model = 0;
    logic [7:0] expb [RXMAX];
    logic [7:0] rx   [RXMAX];
    int         rx_n = 0;
    int         zero_err = 0;
    bit         mon_arm = 0, mon_half = 0;
    int         mon_l = 1;
    logic [7:0] mon_sync = 8'hA5;
    logic [7:0] win [NL];
    bit         aligned = 0, sub = 0;
    int         cnt = 0, nfill = 0;

    burst_frame_buffer #(.NUM_LINKS(NL), .BURST_FRAMES(FR), .FRAME_BYTES(FB)) u_burst_frame_buffer (
        .clk(clk), .rst_n(rst_n), .burst_trig_i(trig), .pix_valid_i(pv), .pix_sof_i(psof),
        .pix_eof_i(peof), .pix_data_i(pdata), .cfg_links_i(cfg_links), .cfg_half_rate_i(cfg_half),
        .link_o(link), .busy_o(busy), .overflow_o(ovf)
    );

    always #5 clk = ~clk;

    // Link monitor: deserializes, aligns on a sync byte seen on link 0, then collects groups.
    always @(negedge clk) begin
        if (!mon_arm) begin
            aligned = 0; sub = 0; cnt = 0; nfill = 0;
            for (int l = 0; l < NL; l++) win[l] = 8'h00;
        end else if (!mon_half || sub) begin
            sub = ~sub;
            for (int l = 0; l < NL; l++) win[l] = {win[l][6:0], link[l]};
            for (int l = mon_l; l < NL; l++) if (link[l] !== 1'b0) zero_err++;
            if (nfill < 8) nfill++;
            if (!aligned) begin
                if (nfill == 8 && win[0] == mon_sync) begin
                    aligned = 1; cnt = 0;
                    for (int l = 0; l < mon_l; l++) if (rx_n < RXMAX) begin rx[rx_n] = win[l]; rx_n++; end
                end
            end else begin
                cnt++;
                if (cnt == 8) begin
                    cnt = 0;
                    for (int l = 0; l < mon_l; l++) if (rx_n < RXMAX) begin rx[rx_n] = win[l]; rx_n++; end
                end
            end
        end else begin
            sub = ~sub;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] s, input int f, input int i);
        return s + 8'(f * 29) + 8'(i * 7);
    endfunction

    task automatic build_exp(input logic [7:0] seed);
        for (int i = 0; i < RXMAX; i++) expb[i] = 8'h3C;
        for (int f = 0; f < FR; f++) begin
            logic [15:0] fnv, sum;
            fnv = 16'(fn_model + f);
            sum = 16'h0;
            expb[f*PER]     = 8'hA5;
            expb[f*PER + 1] = fnv[15:8];
            expb[f*PER + 2] = fnv[7:0];
            for (int i = 0; i < FB; i++) begin
                expb[f*PER + 3 + i] = pat(seed, f, i);
                sum = sum + 16'(pat(seed, f, i));
            end
            expb[f*PER + PER - 2] = sum[15:8];
            expb[f*PER + PER - 1] = sum[7:0];
        end
    endtask

    task automatic feed_frame(input int f, input logic [7:0] seed, input bit gap);
        for (int i = 0; i < FB; i++) begin
            @(negedge clk);
            pv = 1'b1; psof = (i == 0); peof = (i == FB - 1); pdata = pat(seed, f, i);
            if (gap && (i % 3 == 1)) begin
                @(negedge clk);
                pv = 1'b0; psof = 1'b0; peof = 1'b0;
            end
        end
        @(negedge clk);
        pv = 1'b0; psof = 1'b0; peof = 1'b0;
    endtask

    task automatic run_burst(input logic [3:0] lcfg, input bit half, input logic [7:0] seed,
                             input bit gap, input int expl, input bit pre_ign, input bit ovf_tst);
        string lbl;
        lbl = half ? "R4 R6 R7 stream" : "R3 R4 R7 stream";
        cfg_links = LW'(lcfg); cfg_half = half;
        repeat (40) @(negedge clk);
        if (pre_ign) feed_frame(0, ~seed, 1'b0);   // R2: ignored while idle
        build_exp(seed);
        mon_l = expl; mon_half = half; mon_sync = 8'hA5; rx_n = 0; zero_err = 0;
        @(negedge clk); mon_arm = 1;
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        chk(busy == 1'b1, "R2 busy after trigger", busy, 1);
        for (int f = 0; f < FR; f++) feed_frame(f, seed, gap);
        fn_model += FR;
        if (ovf_tst) begin
            feed_frame(0, 8'h55, 1'b0);            // R9: frame while buffer full
            chk(ovf == 1'b1, "R9 overflow set", ovf, 1);
            trig = 1'b1;                           // R8: refused trigger
            @(negedge clk); trig = 1'b0;
        end
        while (rx_n < TOTAL) @(negedge clk);
        mon_arm = 0;
        for (int i = 0; i < rx_n; i++)
            chk(rx[i] == expb[i], (i >= TOTAL) ? "R4 pad" : lbl, rx[i], expb[i]);
        chk(zero_err == 0, "R5 unused links low", zero_err, 0);
        chk(busy == 1'b0, "R11 busy released", busy, 0);
        if (ovf_tst) begin
            repeat (30) @(negedge clk);
            chk(busy == 1'b0, "R8 trigger while busy ignored", busy, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(ovf == 1'b0, "R1 overflow in reset", ovf, 0);
        chk(link == '0, "R1 links in reset", int'(link), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 5; v++)
            run_burst(VECS[v].links, VECS[v].half, VECS[v].seed, VECS[v].gap,
                      int'(VECS[v].exp_l), 1'b0, 1'b0);

        // Directed: ignored idle frame, overflow frame and refused trigger during drain
        run_burst(4'd5, 1'b0, 8'h77, 1'b0, 5, 1'b1, 1'b1);
        // R9 sticky and frame number not advanced by the dropped frame (R7)
        run_burst(4'd2, 1'b1, 8'hC3, 1'b1, 2, 1'b0, 1'b0);
        chk(ovf == 1'b1, "R9 overflow sticky", ovf, 1);

        // R10: idle pattern on active links with the buffer empty
        cfg_links = LW'(2); cfg_half = 1'b0;
        repeat (40) @(negedge clk);
        mon_l = 2; mon_half = 0; mon_sync = 8'h3C; rx_n = 0; zero_err = 0;
        @(negedge clk); mon_arm = 1;
        while (rx_n < 8) @(negedge clk);
        mon_arm = 0;
        for (int i = 0; i < 8; i++) chk(rx[i] == 8'h3C, "R10 idle byte", rx[i], 8'h3C);
        chk(zero_err == 0, "R5 unused links low in idle", zero_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule